// File: doc/BRIEF.md
# Pseudo-Random Word Generator

This block turns a pair of chained linear feedback shift registers into a stream of 32-bit pseudo-random words for a host. A 42-stage maximal-length sequence generator acts as the entropy input. Its output bit is mixed into the feedback of a 128-stage generator. The 128-stage generator yields one bit per running clock. The bits are packed into words, and each finished word is queued in a 16-entry FIFO. The host pops the words one at a time.

The read side works as a stream with back-pressure. `word_avail` acts as the valid flag. A `host_rd` pulse is the consuming handshake and pops the head word shown on `rd_data`. When the FIFO fills, the generator stalls completely: no register advances until the host makes room. Popping from an empty FIFO is not a handshake. It returns zero and raises a sticky underflow flag. While the generator is stalled, the host may reseed the 128-stage register.

Top module: `rng_word_gen`

## Requirements
- R1: The main generator is a 128-bit Fibonacci register `m`. On every running clock its output bit is `m[127]`, and it shifts as `m <= {m[126:0], m[127]^m[125]^m[100]^m[98]^p[41]}`. Here `p[41]` is the entropy generator's current output bit.
- R2: The entropy generator is a 42-bit Fibonacci register `p`. On every running clock it shifts as `p <= {p[40:0], p[41]^p[40]^p[19]^p[18]}`. After reset `p` holds 42'h155_5555_5AA5 and `m` holds 128'h0123456789ABCDEFFEDCBA9876543210.
- R3: Each group of 32 consecutive output bits forms one word. The first bit of the group lands in bit 31 and the last in bit 0. A word enters the FIFO on the 32nd running clock of its group, so the first word is counted on the 32nd clock edge after reset release.
- R4: The FIFO holds up to 16 words and returns them in generation order. `fill` reports the number of queued words, from 0 to 16.
- R5: A running clock is any clock on which `fill` is below 16. At 16 both generators and the bit counter hold their state, and generation resumes exactly where it stopped once a word is popped.
- R6: While `fill` is nonzero, `rd_data` shows the head word and `word_avail` is 1. A `host_rd` pulse removes that word at the next clock edge.
- R7: While `fill` is 0, `rd_data` reads 0. A `host_rd` then sets the sticky `uflow` flag on the next edge, and this set takes priority over a simultaneous clear.
- R8: A `uflow_clr` pulse clears `uflow` at the next edge when no new underflow occurs in the same cycle.
- R9: A `seed_load` pulse copies `seed_val` into `m` only while `fill` is 16. At any other time it has no effect on the word stream.
- R10: During reset `fill` is 0, `word_avail` is 0, `uflow` is 0 and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_rd | input | 1 | Pop request for the head word |
| rd_data | output | 32 | Head word, or zero when empty |
| word_avail | output | 1 | Valid flag: at least one word queued |
| fill | output | 5 | Number of queued words |
| uflow | output | 1 | Sticky empty-read flag |
| uflow_clr | input | 1 | Clears `uflow` |
| seed_load | input | 1 | Reseed request for the main register |
| seed_val | input | 128 | Seed value for the main register |

## Verification
The bench uses the default parameters: 32-bit words and a 16-entry FIFO. Because generation stalls only on word boundaries, the expected word sequence does not depend on timing. The bench computes the words arithmetically from the recurrences, including one reseed.

The short depth lets the bench cover every fill level from 0 to 16, checking each one clock before and on the edge where it is reached. It also holds the generator stalled at full, drains the FIFO, and follows generation as it resumes. The empty-read and flag-clear priority cases are exercised in the first cycles after reset.

// File: rtl/rng_pkg.sv
package rng_pkg;
  localparam int unsigned MAIN_N = 128;
  localparam int unsigned PN_N   = 42;
  localparam logic [MAIN_N-1:0] MAIN_TAPS =
    (128'd1 << 127) | (128'd1 << 125) | (128'd1 << 100) | (128'd1 << 98);
  localparam logic [PN_N-1:0] PN_TAPS =
    (42'd1 << 41) | (42'd1 << 40) | (42'd1 << 19) | (42'd1 << 18);
  localparam logic [MAIN_N-1:0] MAIN_SEED = 128'h0123456789ABCDEFFEDCBA9876543210;
  localparam logic [PN_N-1:0]   PN_SEED   = 42'h155_5555_5AA5;
endpackage

// File: rtl/rng_lfsr.sv
module rng_lfsr #(
  parameter int unsigned N = 42,
  parameter logic [N-1:0] TAPS = '1,
  parameter logic [N-1:0] SEED = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         load,
  input  logic [N-1:0] load_val,
  input  logic         inj,
  output logic         out_bit
);
  logic [N-1:0] s;
  logic         fb;

  assign fb      = (^(s & TAPS)) ^ inj;
  assign out_bit = s[N-1];

  always_ff @(posedge clk) begin
    if (!rst_n)    s <= SEED;
    else if (load) s <= load_val;
    else if (step) s <= {s[N-2:0], fb};
  end

  // R5: a stalled register holds its state
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> $stable(s));
endmodule

// File: rtl/rng_packer.sv
module rng_packer #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              bit_in,
  output logic              push,
  output logic [WORD_W-1:0] word
);
  localparam int unsigned CW = $clog2(WORD_W);
  localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);

  logic [CW-1:0]     cnt;
  logic [WORD_W-1:0] sr;

  assign push = step && (cnt == LAST);
  assign word = {sr[WORD_W-2:0], bit_in};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      sr  <= '0;
    end else if (step) begin
      cnt <= cnt + 1'b1;
      sr  <= word;
    end
  end

  // R3: words are spaced by the full bit count
  a_r3_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> !push);
endmodule

// File: rtl/rng_fifo.sv
module rng_fifo #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned DEPTH  = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [WORD_W-1:0]          push_data,
  input  logic                       pop,
  output logic [WORD_W-1:0]          head,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CNW = $clog2(DEPTH + 1);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wp, rp;

  assign head = (count != '0) ? mem[rp] : '0;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (count != CNW'(DEPTH)));
  a_r4_count_up: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> (count == $past(count) + 1'b1));
  a_r7_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |-> (head == '0));
endmodule

// File: rtl/rng_word_gen.sv
module rng_word_gen #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned DEPTH  = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        host_rd,
  output logic [WORD_W-1:0]           rd_data,
  output logic                        word_avail,
  output logic [$clog2(DEPTH+1)-1:0]  fill,
  output logic                        uflow,
  input  logic                        uflow_clr,
  input  logic                        seed_load,
  input  logic [rng_pkg::MAIN_N-1:0]  seed_val
);
  import rng_pkg::*;
  localparam int unsigned CNW = $clog2(DEPTH + 1);

  logic full, run, pn_bit, gen_bit, push, pop, empty_rd;
  logic [WORD_W-1:0] word;

  assign full       = (fill == CNW'(DEPTH));
  assign run        = !full;
  assign pop        = host_rd && (fill != '0);
  assign empty_rd   = host_rd && (fill == '0);
  assign word_avail = (fill != '0);

  rng_lfsr #(.N(PN_N), .TAPS(PN_TAPS), .SEED(PN_SEED)) u_pn (
    .clk(clk), .rst_n(rst_n), .step(run), .load(1'b0),
    .load_val('0), .inj(1'b0), .out_bit(pn_bit));

  rng_lfsr #(.N(MAIN_N), .TAPS(MAIN_TAPS), .SEED(MAIN_SEED)) u_main (
    .clk(clk), .rst_n(rst_n), .step(run), .load(seed_load && full),
    .load_val(seed_val), .inj(pn_bit), .out_bit(gen_bit));

  rng_packer #(.WORD_W(WORD_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .step(run), .bit_in(gen_bit),
    .push(push), .word(word));

  rng_fifo #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(word),
    .pop(pop), .head(rd_data), .count(fill));

  always_ff @(posedge clk) begin
    if (!rst_n)         uflow <= 1'b0;
    else if (empty_rd)  uflow <= 1'b1;
    else if (uflow_clr) uflow <= 1'b0;
  end

  a_r7_uflow_set: assert property (@(posedge clk) disable iff (!rst_n)
    empty_rd |=> uflow);
  a_r8_uflow_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (uflow_clr && !empty_rd) |=> !uflow);
  a_r5_full_no_push: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push);
endmodule

// File: tb/rng_word_gen_test.sv
module rng_word_gen_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_rd = 1'b0, uflow_clr = 1'b0, seed_load = 1'b0;
  logic [127:0] seed_val = '0;
  logic [31:0] rd_data;
  logic word_avail, uflow;
  logic [4:0] fill;

  localparam logic [127:0] SEED2 = 128'hA5A5_0F0F_1234_5678_9ABC_DEF0_CAFE_F00D;

  int tests = 0, fails = 0, cyc = 0, wd = 0;
  logic [127:0] bm;
  logic [41:0]  bp;
  logic [31:0]  expw [24];

  always #2 clk = ~clk;

  rng_word_gen uut (
    .clk(clk), .rst_n(rst_n), .host_rd(host_rd), .rd_data(rd_data),
    .word_avail(word_avail), .fill(fill), .uflow(uflow),
    .uflow_clr(uflow_clr), .seed_load(seed_load), .seed_val(seed_val));

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic adv();
    @(negedge clk);
    cyc++;
  endtask

  task automatic model_word(output logic [31:0] w);
    logic pfb, mfb, pout;
    for (int b = 0; b < 32; b++) begin
      w    = {w[30:0], bm[127]};
      pout = bp[41];
      pfb  = bp[41] ^ bp[40] ^ bp[19] ^ bp[18];
      mfb  = bm[127] ^ bm[125] ^ bm[100] ^ bm[98] ^ pout;
      bm   = {bm[126:0], mfb};
      bp   = {bp[40:0], pfb};
    end
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    bm = 128'h0123456789ABCDEFFEDCBA9876543210;
    bp = 42'h155_5555_5AA5;
    for (int i = 0; i < 16; i++) model_word(expw[i]);
    bm = SEED2;
    for (int i = 16; i < 24; i++) model_word(expw[i]);

    repeat (3) @(negedge clk);
    check("R10 fill", fill, 0);
    check("R10 avail", word_avail, 0);
    check("R10 uflow", uflow, 0);
    check("R10 rd_data", rd_data, 0);
    rst_n = 1'b1;

    // R7: empty read returns zero and sets flag
    host_rd = 1'b1;
    check("R7 empty data", rd_data, 0);
    adv();
    check("R7 uflow set", uflow, 1);
    uflow_clr = 1'b1;
    adv();
    check("R7 set beats clear", uflow, 1);
    host_rd = 1'b0;
    adv();
    check("R8 clear", uflow, 0);
    uflow_clr = 1'b0;
    adv();
    check("R8 stays clear", uflow, 0);

    // R3/R4: fill sweep at every word boundary
    for (int k = 1; k <= 16; k++) begin
      if (k == 4) begin
        while (cyc < 99) adv();
        seed_load = 1'b1; seed_val = SEED2;   // R9: ignored while running
        adv();
        seed_load = 1'b0;
      end
      while (cyc < 32*k - 1) adv();
      check("R3 fill before edge", fill, k - 1);
      adv();
      check("R4 fill at edge", fill, k);
      check("R6 avail", word_avail, 1);
      if (k == 1) check("R1 R2 R3 first word", rd_data, expw[0]);
    end

    // R5: stall while full
    repeat (40) adv();
    check("R5 held full", fill, 16);
    seed_load = 1'b1; seed_val = SEED2;       // R9: accepted while full
    adv();
    seed_load = 1'b0;
    check("R9 fill unchanged", fill, 16);

    host_rd = 1'b1;
    for (int i = 0; i < 16; i++) begin
      check("R4 R6 order", rd_data, expw[i]);
      adv();
    end
    host_rd = 1'b0;
    check("R6 drained", fill, 0);

    for (int i = 16; i < 24; i++) begin
      while (fill == 0) adv();
      check("R5 R9 resumed word", rd_data, expw[i]);
      host_rd = 1'b1;
      adv();
      host_rd = 1'b0;
    end
    check("R7 no spurious uflow", uflow, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule